// File: doc/BRIEF.md
# Bus Address Image Decoder

This block decides whether a 32-bit bus address falls inside one of several programmable address windows, called images, and which one it is. Each image holds a base address, a size mask, a translation base and three control bits: enable, space select (memory or IO) and translation enable. Only the top `DEC_BITS` bits of an address take part in the decode. The mask then narrows the compare further: where a mask bit is cleared, that address bit is a don't-care, and the window grows.

A bus front end presents an address with `addr_vld` for one cycle, together with the access's space type. A fixed number of cycles later, set by `WAIT_STATES` (1, 2 or 3), the block pulses `rsp_vld` and updates three registered results: a hit flag, the index of the winning image and the output address. When the winning image has translation switched on, the output address has its masked-in upper bits taken from the translation base. The results hold their values until the next decode completes. Images are programmed through a simple one-cycle register write port.

Top module: `img_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_vld`, `hit`, `hit_idx` and `addr_out` are all zero.
- R2: After reset, every mask register covers all `DEC_BITS` top bits. An enabled image with no mask write therefore spans exactly 2^(32-DEC_BITS) bytes, which is 4 KB with the default of 20.
- R3: An address bit is compared against the base only where the mask bit is 1. Clearing low-order mask bits enlarges the window. The mask is written with `cfg_field`=1, base with 0, translation with 2 and control with 3. Data for these fields is taken from the top `DEC_BITS` bits of `cfg_wdata`.
- R4: An image whose enable bit (control bit 0) is 0 never matches.
- R5: An image matches only when its space bit (control bit 1; 0 = memory, 1 = IO) equals `addr_io`.
- R6: When several images match, the lowest-numbered one is reported in `hit_idx`.
- R7: On a miss, `hit` is 0, `hit_idx` is 0 and `addr_out` equals the sampled input address.
- R8: On a hit where translation is off (control bit 2 is 0, or `XLAT_IMPL` is 0), `addr_out` equals the input address, whatever the translation register holds.
- R9: On a hit where translation is on, each output bit whose mask bit is 1 comes from the translation register. Every other output bit comes from the input address.
- R10: `rsp_vld` pulses for one cycle exactly `WAIT_STATES` clock edges after the edge that samples `addr_vld`. The results appear at that same edge.
- R11: `hit`, `hit_idx` and `addr_out` change only at an edge where `rsp_vld` rises. Register writes and new input addresses leave them unchanged in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | IDX_W | Image number to write |
| cfg_field | input | 2 | Field to write: 0 base, 1 mask, 2 translation, 3 control |
| cfg_wdata | input | 32 | Write data (address fields from the top bits; control in bits 2:0) |
| addr_vld | input | 1 | Address strobe, one cycle per decode |
| addr_in | input | 32 | Address to decode |
| addr_io | input | 1 | Access space: 0 memory, 1 IO |
| rsp_vld | output | 1 | One-cycle pulse when a decode result is updated |
| hit | output | 1 | Some enabled image matched |
| hit_idx | output | IDX_W | Index of the winning image |
| addr_out | output | 32 | Translated or passed-through address |

## Verification
The bench probes the byte on each side of a window edge. It uses both the reset-size window and a mask-enlarged window, so an off-by-one in mask handling shows up as a hit just outside the window or a miss just inside it. Overlapping images check the priority order, both before and after the lower image is disabled; a design that scans in the wrong order reports the higher index. The bench then flips the translation and space bits one at a time on the same address. A design that ignores the enable or space bit, or that always translates, returns the wrong `addr_out` or a false hit. Latency is checked on every probe, cycle by cycle, and the held results are rechecked after register writes; an early or late pulse, or outputs that follow configuration changes, are reported.

// File: rtl/img_dec_pkg.sv
package img_dec_pkg;

    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_MASK = 2'd1,
        FLD_XLAT = 2'd2,
        FLD_CTRL = 2'd3
    } cfg_field_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_IO_BIT = 1;
    localparam int CTRL_XL_BIT = 2;

    // one image; address fields are kept 32-bit aligned, undecoded bits are zero
    typedef struct packed {
        logic [31:0] base;
        logic [31:0] mask;
        logic [31:0] xlat;
        logic        en;
        logic        io;
        logic        xl;
    } img_cfg_t;

    // ones in the n most significant bits
    function automatic logic [31:0] top_ones(input int n);
        return ~(32'hFFFF_FFFF >> n);
    endfunction

    function automatic logic window_hit(input img_cfg_t c, input logic [31:0] a,
                                        input logic io);
        return c.en && (c.io == io) && (((a ^ c.base) & c.mask) == 32'd0);
    endfunction

    function automatic logic [31:0] apply_xlat(input img_cfg_t c, input logic [31:0] a,
                                               input logic impl);
        if (impl && c.xl)
            return (c.xlat & c.mask) | (a & ~c.mask);
        return a;
    endfunction

endpackage

// File: rtl/img_cfg_regs.sv
module img_cfg_regs
    import img_dec_pkg::*;
#(
    parameter int NUM_IMG  = 4,
    parameter int DEC_BITS = 20,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  sel,
    input  logic [1:0]        field,
    input  logic [31:0]       wdata,
    output img_cfg_t          cfg [NUM_IMG]
);
    localparam logic [31:0] FLD_M = top_ones(DEC_BITS);

    cfg_field_e fsel;
    assign fsel = cfg_field_e'(field);

    for (genvar g = 0; g < NUM_IMG; g++) begin : g_img
        logic wr_me;
        assign wr_me = we && (sel == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g].base <= '0;
                cfg[g].mask <= FLD_M;
                cfg[g].xlat <= '0;
                cfg[g].en   <= 1'b0;
                cfg[g].io   <= 1'b0;
                cfg[g].xl   <= 1'b0;
            end else if (wr_me) begin
                case (fsel)
                    FLD_BASE: cfg[g].base <= wdata & FLD_M;
                    FLD_MASK: cfg[g].mask <= wdata & FLD_M;
                    FLD_XLAT: cfg[g].xlat <= wdata & FLD_M;
                    FLD_CTRL: begin
                        cfg[g].en <= wdata[CTRL_EN_BIT];
                        cfg[g].io <= wdata[CTRL_IO_BIT];
                        cfg[g].xl <= wdata[CTRL_XL_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/img_delay.sv
module img_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    if (DEPTH == 0) begin : g_wire
        assign dout = din;
        logic unused_ok;
        assign unused_ok = &{1'b0, clk, rst};
    end else begin : g_regs
        logic [W-1:0] q [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int k = 0; k < DEPTH; k++) q[k] <= '0;
            end else begin
                q[0] <= din;
                for (int k = 1; k < DEPTH; k++) q[k] <= q[k-1];
            end
        end
        assign dout = q[DEPTH-1];
    end
endmodule

// File: rtl/img_select.sv
module img_select
    import img_dec_pkg::*;
#(
    parameter int NUM_IMG   = 4,
    parameter int IDX_W     = 2,
    parameter bit XLAT_IMPL = 1'b1
) (
    input  logic [NUM_IMG-1:0] match,
    input  img_cfg_t           cfg [NUM_IMG],
    input  logic [31:0]        addr,
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [31:0]        addr_o
);
    img_cfg_t pick;

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        pick = '0;
        // scan downward so the lowest-numbered match is left standing
        for (int i = NUM_IMG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                pick = cfg[i];
            end
        end
        addr_o = hit ? apply_xlat(pick, addr, XLAT_IMPL) : addr;
    end
endmodule

// File: rtl/img_decoder.sv
module img_decoder
    import img_dec_pkg::*;
#(
    parameter int NUM_IMG     = 4,
    parameter int DEC_BITS    = 20,
    parameter int WAIT_STATES = 2,
    parameter bit XLAT_IMPL   = 1'b1,
    localparam int IDX_W      = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic [1:0]       cfg_field,
    input  logic [31:0]      cfg_wdata,
    input  logic             addr_vld,
    input  logic [31:0]      addr_in,
    input  logic             addr_io,
    output logic             rsp_vld,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [31:0]      addr_out
);
    localparam int DLY   = WAIT_STATES - 1;
    localparam int BUS_W = 1 + 32 + NUM_IMG;

    img_cfg_t cfg [NUM_IMG];

    img_cfg_regs #(.NUM_IMG(NUM_IMG), .DEC_BITS(DEC_BITS), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
        .field(cfg_field), .wdata(cfg_wdata), .cfg(cfg)
    );

    // capture stage: first wait state
    logic        s0_vld;
    logic [31:0] s0_addr;
    logic        s0_io;
    always_ff @(posedge clk) begin
        if (rst) begin
            s0_vld  <= 1'b0;
            s0_addr <= '0;
            s0_io   <= 1'b0;
        end else begin
            s0_vld <= addr_vld;
            if (addr_vld) begin
                s0_addr <= addr_in;
                s0_io   <= addr_io;
            end
        end
    end

    logic [NUM_IMG-1:0] match;
    for (genvar g = 0; g < NUM_IMG; g++) begin : g_cmp
        assign match[g] = window_hit(cfg[g], s0_addr, s0_io);
    end

    // extra wait states
    logic [BUS_W-1:0]   d_bus;
    logic               d_vld;
    logic [31:0]        d_addr;
    logic [NUM_IMG-1:0] d_match;
    img_delay #(.W(BUS_W), .DEPTH(DLY)) u_dly (
        .clk(clk), .rst(rst),
        .din({s0_vld, s0_addr, match}),
        .dout(d_bus)
    );
    assign {d_vld, d_addr, d_match} = d_bus;

    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    logic [31:0]      sel_addr;
    img_select #(.NUM_IMG(NUM_IMG), .IDX_W(IDX_W), .XLAT_IMPL(XLAT_IMPL)) u_sel (
        .match(d_match), .cfg(cfg), .addr(d_addr),
        .hit(sel_hit), .idx(sel_idx), .addr_o(sel_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            hit      <= 1'b0;
            hit_idx  <= '0;
            addr_out <= '0;
        end else begin
            rsp_vld <= d_vld;
            if (d_vld) begin
                hit      <= sel_hit;
                hit_idx  <= sel_idx;
                addr_out <= sel_addr;
            end
        end
    end
endmodule

// File: rtl/img_decoder_chk.sv
module img_decoder_chk #(
    parameter int WAIT_STATES = 2,
    parameter int IDX_W       = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_vld,
    input logic             rsp_vld,
    input logic             hit,
    input logic [IDX_W-1:0] hit_idx,
    input logic [31:0]      addr_out
);
    logic [WAIT_STATES:0] vld_hist;
    always_ff @(posedge clk) begin
        if (rst) vld_hist <= '0;
        else     vld_hist <= {vld_hist[WAIT_STATES-1:0], addr_vld};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rsp_vld && !hit && hit_idx == '0 && addr_out == '0));

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld == vld_hist[WAIT_STATES]);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_vld |-> ($stable(hit) && $stable(hit_idx) && $stable(addr_out)));

    // R7
    miss_idx_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |-> hit_idx == '0);
endmodule

bind img_decoder img_decoder_chk #(.WAIT_STATES(WAIT_STATES), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .addr_vld(addr_vld), .rsp_vld(rsp_vld),
    .hit(hit), .hit_idx(hit_idx), .addr_out(addr_out)
);

// File: tb/sim_img_decoder.sv
module sim_img_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT       = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        addr_vld = 1'b0;
    logic [31:0] addr_in = '0;
    logic        addr_io = 1'b0;
    logic        rsp_vld;
    logic        hit;
    logic [1:0]  hit_idx;
    logic [31:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    img_decoder #(.NUM_IMG(4), .DEC_BITS(20), .WAIT_STATES(WAIT), .XLAT_IMPL(1'b1)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .addr_vld(addr_vld),
        .addr_in(addr_in), .addr_io(addr_io), .rsp_vld(rsp_vld), .hit(hit),
        .hit_idx(hit_idx), .addr_out(addr_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int img, input logic [1:0] fld, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = img[1:0]; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one decode: latency (R10), result, then hold for one cycle (R11)
    task automatic probe(input logic [31:0] a, input logic io, input logic eh,
                         input logic [1:0] ei, input logic [31:0] ea, input string req);
        @(negedge clk);
        addr_in = a; addr_io = io; addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0; addr_in = 32'hDEAD_BEEF; addr_io = ~io;
        for (int k = 0; k < WAIT; k++) begin
            chk(rsp_vld == 1'b0, "R10", "early rsp_vld", {31'd0, rsp_vld}, 32'd0);
            @(negedge clk);
        end
        chk(rsp_vld == 1'b1, "R10", "rsp_vld on time", {31'd0, rsp_vld}, 32'd1);
        chk(hit == eh, req, "hit", {31'd0, hit}, {31'd0, eh});
        chk(hit_idx == ei, req, "hit_idx", {30'd0, hit_idx}, {30'd0, ei});
        chk(addr_out == ea, req, "addr_out", addr_out, ea);
        @(negedge clk);
        chk(rsp_vld == 1'b0, "R10", "rsp_vld one cycle", {31'd0, rsp_vld}, 32'd0);
        chk(addr_out == ea && hit == eh, "R11", "hold", addr_out, ea);
    endtask

    task automatic t_reset;
        chk(!rsp_vld && !hit, "R1", "flags in reset", {30'd0, rsp_vld, hit}, 32'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(!rsp_vld && !hit && hit_idx == 2'd0, "R1", "flags after reset",
            {29'd0, rsp_vld, hit_idx}, 32'd0);
        chk(addr_out == 32'd0, "R1", "addr after reset", addr_out, 32'd0);
    endtask

    task automatic t_default_size;
        wr(0, 2'd0, 32'h0000_0000);
        wr(0, 2'd3, 32'h1);
        probe(32'h0000_0FFC, 1'b0, 1'b1, 2'd0, 32'h0000_0FFC, "R2");
        probe(32'h0000_1000, 1'b0, 1'b0, 2'd0, 32'h0000_1000, "R2");
    endtask

    task automatic t_mask;
        wr(1, 2'd0, 32'h4000_0000);
        wr(1, 2'd1, 32'hFFF0_0000);
        wr(1, 2'd3, 32'h1);
        probe(32'h400F_FFF0, 1'b0, 1'b1, 2'd1, 32'h400F_FFF0, "R3");
        probe(32'h4010_0000, 1'b0, 1'b0, 2'd0, 32'h4010_0000, "R3");
        probe(32'h3FFF_FFFC, 1'b0, 1'b0, 2'd0, 32'h3FFF_FFFC, "R7");
    endtask

    task automatic t_disabled_and_space;
        wr(2, 2'd0, 32'h8000_0000);
        wr(2, 2'd3, 32'h2);
        probe(32'h8000_0010, 1'b1, 1'b0, 2'd0, 32'h8000_0010, "R4");
        wr(2, 2'd3, 32'h3);
        probe(32'h8000_0010, 1'b0, 1'b0, 2'd0, 32'h8000_0010, "R5");
        probe(32'h8000_0010, 1'b1, 1'b1, 2'd2, 32'h8000_0010, "R5");
    endtask

    task automatic t_priority_xlat;
        wr(3, 2'd0, 32'h4000_0000);
        wr(3, 2'd2, 32'hABCD_E000);
        wr(3, 2'd3, 32'h1);
        probe(32'h4000_0020, 1'b0, 1'b1, 2'd1, 32'h4000_0020, "R6");
        wr(1, 2'd3, 32'h0);
        probe(32'h4000_0020, 1'b0, 1'b1, 2'd3, 32'h4000_0020, "R8");
        wr(3, 2'd3, 32'h5);
        probe(32'h4000_0020, 1'b0, 1'b1, 2'd3, 32'hABCD_E020, "R9");
        wr(3, 2'd3, 32'h0);
        wr(1, 2'd2, 32'h123F_F000);
        wr(1, 2'd3, 32'h5);
        probe(32'h400A_BCD4, 1'b0, 1'b1, 2'd1, 32'h123A_BCD4, "R9");
    endtask

    task automatic t_hold;
        wr(1, 2'd3, 32'h0);
        wr(1, 2'd2, 32'h0);
        @(negedge clk);
        chk(hit == 1'b1 && hit_idx == 2'd1, "R11", "hit held over writes",
            {29'd0, hit, hit_idx}, 32'h5);
        chk(addr_out == 32'h123A_BCD4, "R11", "addr held over writes",
            addr_out, 32'h123A_BCD4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_default_size();
        t_mask();
        t_disabled_and_space();
        t_priority_xlat();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule